// File: doc/BRIEF.md
# Power-Down Mode Controller

This block sets the power state of a small mixed-signal device that has a bank of DAC channels and a non-volatile memory. Three sources control it. The first is an active-low hardware power-down pin. The second is a pair of one-cycle command strobes from the serial command decoder: one enters power-down and one leaves it. The third is the chip-select level. From these the block drives three outputs: a standby enable for the DAC section, a standby enable for the memory section, and a high-impedance enable for the analog outputs.

A one-bit software power-down latch records the last command that was accepted. It is built as a two-state machine with the states `LATCH_RUN` and `LATCH_DOWN`. The transition `go_down` is taken on an accepted enter strobe and `go_up` on an accepted leave strobe. While the pin is low the pin wins: the device is powered down, and both strobes are dropped without touching the latch.

A combinational decoder turns the pin, the latch and chip select into one of three levels:
- `LVL_NORMAL`: everything is awake.
- `LVL_DAC_ONLY`: the DAC sleeps and the outputs float, while the memory stays awake.
- `LVL_FULL`: the memory sleeps as well.

The choice between `LVL_DAC_ONLY` and `LVL_FULL` follows chip select in the same cycle. A memory program cycle that is still busy forces the `LVL_DAC_ONLY` level.

Top module: `pdc_power_ctrl`

## Requirements
- R1: Reset clears the software latch. After reset is released with the pin high and no strobes, all three outputs are 0.
- R2: While `pd_pin_n` is 0, `dac_standby` and `aout_hiz` are 1 in the same cycle, whatever the latch holds.
- R3: A strobe of either kind that arrives while `pd_pin_n` is 0 leaves the latch unchanged. This is visible at the outputs once the pin returns high.
- R4: With `pd_pin_n` at 1, a one-cycle `pden_stb` sets the latch at the next rising clock edge. From the following cycle on, `dac_standby` and `aout_hiz` stay at 1 until a leave strobe is accepted.
- R5: With `pd_pin_n` at 1, a one-cycle `pdds_stb` clears the latch at the next edge. If the pin is still high, the outputs return to 0 from the following cycle.
- R6: A cycle in which both strobes are high leaves the latch unchanged.
- R7: In power-down, `mem_standby` equals `cs_level` in the same cycle (0 selects level 1, 1 selects level 2). Outside power-down, `mem_standby` is 0.
- R8: While `prog_busy` is 1, `mem_standby` is 0, even in power-down with `cs_level` at 1.
- R9: In normal mode all three outputs are 0 for either level of `cs_level`.
- R10: While `rst_n` is 0, the outputs follow the pin and chip select: pin low with CS low gives level 1, pin low with CS high gives level 2, and pin high gives normal mode. Strobes during reset are ignored.
- R11: `aout_hiz` always equals `dac_standby`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pd_pin_n | input | 1 | Hardware power-down, 0 = power down |
| cs_level | input | 1 | Chip-select level, 1 = deselected |
| prog_busy | input | 1 | Memory self-timed program cycle in progress |
| pden_stb | input | 1 | One-cycle enter-power-down command |
| pdds_stb | input | 1 | One-cycle leave-power-down command |
| dac_standby | output | 1 | DAC section standby enable |
| mem_standby | output | 1 | Memory section standby enable |
| aout_hiz | output | 1 | Analog outputs high-impedance enable |

## Verification
The bench targets three cases:
- **Strobes while the pin is low.** A design that lets them reach the latch would come out of a pin-forced power-down still asleep, or awake when it should be asleep.
- **Both strobes in one cycle.** A design that gives either strobe priority would change mode on that cycle.
- **The programming-busy hold.** A design without it would put the memory to sleep in the middle of a write.

The bench also drives chip-select changes within one power-down episode and checks the pin-derived state during reset. A registered level decode would show stale values there, and a reset value that ignores the pins would show normal mode while the pin is low.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic {
        LATCH_RUN  = 1'b0,
        LATCH_DOWN = 1'b1
    } latch_state_t;

    typedef enum logic [1:0] {
        LVL_NORMAL   = 2'd0,
        LVL_DAC_ONLY = 2'd1,
        LVL_FULL     = 2'd2
    } pwr_level_t;

endpackage

// File: rtl/pdc_sw_latch.sv
module pdc_sw_latch
    import pdc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pd_pin_n,
    input  logic         pden_stb,
    input  logic         pdds_stb,
    output latch_state_t state_q
);

    latch_state_t state_d;
    logic         go_down;
    logic         go_up;

    // Strobes are accepted only while the pin is high, and only one at a time.
    always_comb begin
        go_down = pd_pin_n && pden_stb && !pdds_stb;
        go_up   = pd_pin_n && pdds_stb && !pden_stb;
        state_d = state_q;
        unique case (state_q)
            LATCH_RUN:  if (go_down) state_d = LATCH_DOWN;
            LATCH_DOWN: if (go_up)   state_d = LATCH_RUN;
            default:    state_d = LATCH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LATCH_RUN;
        else        state_q <= state_d;
    end

    // R3
    pin_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_pin_n |=> $stable(state_q));

    // R4
    enter_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_pin_n && pden_stb && !pdds_stb) |=> (state_q == LATCH_DOWN));

    // R5
    leave_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_pin_n && pdds_stb && !pden_stb) |=> (state_q == LATCH_RUN));

    // R6
    dual_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pden_stb && pdds_stb) |=> $stable(state_q));

endmodule

// File: rtl/pdc_level_decode.sv
module pdc_level_decode
    import pdc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pd_pin_n,
    input  logic         cs_level,
    input  logic         prog_busy,
    input  latch_state_t latch_q,
    output logic         dac_standby,
    output logic         mem_standby,
    output logic         aout_hiz
);

    pwr_level_t level;
    logic       pd_active;

    always_comb begin
        pd_active = !pd_pin_n || (latch_q == LATCH_DOWN);
        if (!pd_active)                 level = LVL_NORMAL;
        else if (cs_level && !prog_busy) level = LVL_FULL;
        else                            level = LVL_DAC_ONLY;
    end

    always_comb begin
        dac_standby = 1'b0;
        mem_standby = 1'b0;
        aout_hiz    = 1'b0;
        unique case (level)
            LVL_NORMAL: ;
            LVL_DAC_ONLY: begin
                dac_standby = 1'b1;
                aout_hiz    = 1'b1;
            end
            LVL_FULL: begin
                dac_standby = 1'b1;
                aout_hiz    = 1'b1;
                mem_standby = 1'b1;
            end
            default: ;
        endcase
    end

    // R2
    pin_forces_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_pin_n |-> (dac_standby && aout_hiz));

    // R7
    mem_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_standby |-> (cs_level && dac_standby));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> !mem_standby);

    // R11
    hiz_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aout_hiz == dac_standby);

endmodule

// File: rtl/pdc_power_ctrl.sv
module pdc_power_ctrl
    import pdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_pin_n,
    input  logic cs_level,
    input  logic prog_busy,
    input  logic pden_stb,
    input  logic pdds_stb,
    output logic dac_standby,
    output logic mem_standby,
    output logic aout_hiz
);

    latch_state_t latch_q;

    pdc_sw_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_pin_n (pd_pin_n),
        .pden_stb (pden_stb),
        .pdds_stb (pdds_stb),
        .state_q  (latch_q)
    );

    pdc_level_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_pin_n    (pd_pin_n),
        .cs_level    (cs_level),
        .prog_busy   (prog_busy),
        .latch_q     (latch_q),
        .dac_standby (dac_standby),
        .mem_standby (mem_standby),
        .aout_hiz    (aout_hiz)
    );

    // R9
    normal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_pin_n && latch_q == LATCH_RUN) |-> !(dac_standby || mem_standby || aout_hiz));

endmodule

// File: tb/pdc_power_ctrl_test.sv
module pdc_power_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_pin_n = 1'b1;
    logic cs_level = 1'b0;
    logic prog_busy = 1'b0;
    logic pden_stb = 1'b0;
    logic pdds_stb = 1'b0;
    logic dac_standby, mem_standby, aout_hiz;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pdc_power_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_pin_n    (pd_pin_n),
        .cs_level    (cs_level),
        .prog_busy   (prog_busy),
        .pden_stb    (pden_stb),
        .pdds_stb    (pdds_stb),
        .dac_standby (dac_standby),
        .mem_standby (mem_standby),
        .aout_hiz    (aout_hiz)
    );

    // Bits: {pd_pin_n, cs, busy, pden, pdds, exp_standby, exp_mem}.
    // Expected values are seen in the same cycle, before the strobe takes effect.
    localparam int NV = 19;
    localparam logic [6:0] VEC [NV] = '{
        7'b1_0_0_0_0_0_0, // 0  R9 normal, cs low
        7'b1_1_0_0_0_0_0, // 1  R9 normal, cs high
        7'b1_0_0_1_0_0_0, // 2  R4 enter strobe
        7'b1_0_0_0_0_1_0, // 3  R4 R7 level 1
        7'b1_1_0_0_0_1_1, // 4  R7 level 2
        7'b1_1_1_0_0_1_0, // 5  R8 busy holds memory awake
        7'b1_1_0_1_1_1_1, // 6  R6 both strobes
        7'b1_0_0_0_0_1_0, // 7  R6 still down
        7'b1_0_0_0_1_1_0, // 8  R5 leave strobe
        7'b1_1_0_0_0_0_0, // 9  R5 normal again
        7'b0_0_0_1_0_1_0, // 10 R2 pin down, R3 enter ignored
        7'b0_1_0_0_0_1_1, // 11 R2 R7 level 2 from pin
        7'b1_1_0_0_0_0_0, // 12 R3 latch not set by blocked strobe
        7'b1_0_0_1_0_0_0, // 13 R4 enter
        7'b0_1_0_0_1_1_1, // 14 R3 leave ignored while pin low
        7'b1_1_0_0_0_1_1, // 15 R3 latch still set
        7'b1_1_0_0_1_1_1, // 16 R5 leave
        7'b1_1_1_0_0_0_0, // 17 R9 normal with busy
        7'b0_1_1_0_0_1_0  // 18 R8 busy with pin down
    };

    task automatic check(input string tag, input logic exp_s, input logic exp_m);
        checks++;
        if (dac_standby !== exp_s || aout_hiz !== exp_s || mem_standby !== exp_m) begin
            fails++;
            $display("FAIL %s: got stby=%b hiz=%b mem=%b, expected stby=%b hiz=%b mem=%b",
                     tag, dac_standby, aout_hiz, mem_standby, exp_s, exp_s, exp_m);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end

    initial begin
        // R10: during reset outputs follow the pins; strobes ignored.
        pd_pin_n = 1'b0; cs_level = 1'b0;
        #3;  check("R10 pin low cs low", 1'b1, 1'b0);
        cs_level = 1'b1;
        #1;  check("R10 pin low cs high", 1'b1, 1'b1);
        pd_pin_n = 1'b1; pden_stb = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R10 pin high in reset", 1'b0, 1'b0);
        pden_stb = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: latch cleared, normal mode after reset.
        check("R1 after reset", 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {pd_pin_n, cs_level, prog_busy, pden_stb, pdds_stb} = VEC[i][6:2];
            #1;
            check($sformatf("vector %0d", i), VEC[i][1], VEC[i][0]);
        end

        // R7: cs changes within one cycle while down.
        @(negedge clk);
        {pd_pin_n, cs_level, prog_busy, pden_stb, pdds_stb} = 5'b1_0_0_1_0;
        @(negedge clk);
        pden_stb = 1'b0;
        #1; check("R7 level 1", 1'b1, 1'b0);
        cs_level = 1'b1;
        #1; check("R7 cs rise same cycle", 1'b1, 1'b1);
        cs_level = 1'b0;
        #1; check("R7 cs fall same cycle", 1'b1, 1'b0);

        // R1: reset clears a set latch.
        rst_n = 1'b0;
        #1; check("R1 reset clears latch", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 normal after second reset", 1'b0, 1'b0);

        done = 1'b1;
        finish_run();
    end

endmodule